// File: doc/BRIEF.md
# Interrupt Flag and Acknowledge Logic

This block holds the interrupt status of a small 8-bit microcontroller: one latched external interrupt flag and two core-timer flags, one for timer overflow and one for the periodic real-time tick. The external flag is set by a falling edge on a dedicated active-low interrupt pin. When a configuration input allows it, a falling edge on any of four port pins also sets it. All five pins first pass through a two-flop synchronizer. The timer flags are set by single-cycle pulses from a timer counter that lives outside the block.

Software uses a two-register bus to read the flags, program the two timer interrupt enables and clear flags. Each flag is cleared by writing 1 to its own strobe bit, and every strobe bit reads back as 0. The CPU also clears the external flag when it fetches the interrupt vector. The block drives one interrupt request line to the CPU. That line is the OR of the pending external flag and the two enabled timer requests, and it is held low while the global mask is set.

Top module: `intr_flag_ctrl`

## Requirements
- R1: After reset all three flags and both enables are 0, both registers read 0x00 and `cpu_irq` is 0.
- R2: A falling edge on `irq_pin_n` (idle high) sets the external flag, and the flag is visible on the third rising clock edge after the pin changes. A rising edge, or a pin held steady, never sets it.
- R3: A falling edge on any `port_pin_n` bit sets the external flag only while `port_irq_en` is 1. While `port_irq_en` is 0, port pins have no effect.
- R4: The external flag clears on the edge where `vec_fetch` is 1, or on a write to register 0 with data bit 0 set. A write to register 0 with bit 0 clear changes nothing, whatever its bit 7 holds.
- R5: Register 0 (`bus_addr`=0) reads the external flag in bit 7. Its other bits, including the clear strobe in bit 0, read 0.
- R6: A pulse on `ovf_pulse` or `tick_pulse` sets its flag at the next edge. A write to register 1 clears the overflow flag when data bit 3 is 1 and the tick flag when data bit 2 is 1. Reset is the only other way to clear them.
- R7: Register 1 reads {overflow flag, tick flag, overflow enable, tick enable, 0000} from bit 7 down to bit 0. The enables are written through bits 5 and 4, and the clear strobes in bits 3 and 2 read 0.
- R8: When a set event and a clear (strobe write or vector fetch) occur in the same cycle, the flag ends up set.
- R9: `cpu_irq` = !`irq_mask` & (external flag | overflow flag & overflow enable | tick flag & tick enable). It follows the register state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Dedicated external interrupt pin, active low |
| port_pin_n | input | N_PORT | Port pins usable as extra interrupt sources, active low |
| port_irq_en | input | 1 | Configuration enable that lets port pins set the external flag |
| ovf_pulse | input | 1 | One-cycle timer overflow event |
| tick_pulse | input | 1 | One-cycle real-time tick event |
| irq_mask | input | 1 | Global interrupt mask from the CPU condition codes |
| vec_fetch | input | 1 | CPU is fetching the external interrupt vector |
| bus_addr | input | 1 | Register select: 0 external, 1 timer |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| cpu_irq | output | 1 | Masked interrupt request to the CPU |

## Verification
The bench sweeps all 32 combinations of timer flags, enables and mask, and predicts the request arithmetically. A design that leaks a disabled timer flag, or ignores the mask, raises `cpu_irq` in at least one of those cases. Each port pin is tried with the configuration enable both off and on, so a missing gate sets the flag from a port pin that should be ignored. Set and clear are made to collide on the same edge for both kinds of flag; a design that lets the clear win loses the interrupt. Readback is checked after writing 1 to every strobe and to the read-only flag bit, which shows any strobe bit that is stored, or any flag that is writable.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int unsigned DATA_W       = 8;
    localparam logic        ADDR_EXT     = 1'b0;
    localparam logic        ADDR_TMR     = 1'b1;
    // register 0 layout
    localparam int unsigned EXT_PEND_BIT = 7;
    localparam int unsigned EXT_CLR_BIT  = 0;
    // register 1 layout
    localparam int unsigned OVF_FLG_BIT  = 7;
    localparam int unsigned TICK_FLG_BIT = 6;
    localparam int unsigned OVF_EN_BIT   = 5;
    localparam int unsigned TICK_EN_BIT  = 4;
    localparam int unsigned OVF_CLR_BIT  = 3;
    localparam int unsigned TICK_CLR_BIT = 2;

    typedef struct packed {
        logic ext_pend;
        logic ovf_en;
        logic tick_en;
    } ctrl_state_t;

    typedef struct packed {
        logic ovf;
        logic tick;
    } tmr_flags_t;
endpackage

// File: rtl/intr_fall_sync.sv
module intr_fall_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-1:0], pin_n[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end

        assign fall[i] = sh_q[STAGES] & ~sh_q[STAGES-1];
    end
endmodule

// File: rtl/intr_tmr_flags.sv
module intr_tmr_flags
    import intr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_pulse,
    input  logic       tick_pulse,
    input  logic       ovf_clr,
    input  logic       tick_clr,
    output tmr_flags_t flags
);
    tmr_flags_t flg_d, flg_q;

    always_comb begin
        flg_d      = flg_q;
        flg_d.ovf  = ovf_pulse  | (flg_q.ovf  & ~ovf_clr);
        flg_d.tick = tick_pulse | (flg_q.tick & ~tick_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;

    // R8
    ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> flags.ovf);
    // R6
    tick_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_clr && !tick_pulse) |=> !flags.tick);
    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_pulse && !ovf_clr) |=> $stable(flags.ovf));
endmodule

// File: rtl/intr_flag_ctrl.sv
module intr_flag_ctrl
    import intr_pkg::*;
#(
    parameter int unsigned N_PORT      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic [N_PORT-1:0] port_pin_n,
    input  logic              port_irq_en,
    input  logic              ovf_pulse,
    input  logic              tick_pulse,
    input  logic              irq_mask,
    input  logic              vec_fetch,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq
);
    localparam int unsigned N_PIN = N_PORT + 1;

    logic [N_PIN-1:0] fall;
    logic             ext_set, ext_clr, wr_ext, wr_tmr;
    ctrl_state_t      st_d, st_q;
    tmr_flags_t       tflg;

    intr_fall_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n ({port_pin_n, irq_pin_n}),
        .fall  (fall)
    );

    assign wr_ext  = bus_wr && (bus_addr == ADDR_EXT);
    assign wr_tmr  = bus_wr && (bus_addr == ADDR_TMR);
    assign ext_set = fall[0] | (port_irq_en & (|fall[N_PIN-1:1]));
    assign ext_clr = vec_fetch | (wr_ext & bus_wdata[EXT_CLR_BIT]);

    intr_tmr_flags u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_pulse  (ovf_pulse),
        .tick_pulse (tick_pulse),
        .ovf_clr    (wr_tmr & bus_wdata[OVF_CLR_BIT]),
        .tick_clr   (wr_tmr & bus_wdata[TICK_CLR_BIT]),
        .flags      (tflg)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ext_pend = ext_set | (st_q.ext_pend & ~ext_clr);
        if (wr_tmr) begin
            st_d.ovf_en  = bus_wdata[OVF_EN_BIT];
            st_d.tick_en = bus_wdata[TICK_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_EXT) begin
            bus_rdata[EXT_PEND_BIT] = st_q.ext_pend;
        end else begin
            bus_rdata[OVF_FLG_BIT]  = tflg.ovf;
            bus_rdata[TICK_FLG_BIT] = tflg.tick;
            bus_rdata[OVF_EN_BIT]   = st_q.ovf_en;
            bus_rdata[TICK_EN_BIT]  = st_q.tick_en;
        end
    end

    assign cpu_irq = ~irq_mask & (st_q.ext_pend
                                  | (tflg.ovf  & st_q.ovf_en)
                                  | (tflg.tick & st_q.tick_en));

    // R8
    ext_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_set |=> st_q.ext_pend);
    // R4
    ext_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch && !ext_set) |=> !st_q.ext_pend);
    // R9
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !cpu_irq);
    // R5
    ext_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_EXT) |-> (bus_rdata[6:0] == '0));
    // R7
    strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_TMR) |-> (bus_rdata[3:0] == '0));
endmodule

// File: tb/intr_flag_ctrl_tb.sv
`timescale 1ns/1ps
module intr_flag_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic [3:0] port_pin_n = 4'hF;
    logic       port_irq_en = 1'b0;
    logic       ovf_pulse = 1'b0, tick_pulse = 1'b0;
    logic       irq_mask = 1'b0, vec_fetch = 1'b0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cpu_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intr_flag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pin_n(port_pin_n),
        .port_irq_en(port_irq_en), .ovf_pulse(ovf_pulse), .tick_pulse(tick_pulse),
        .irq_mask(irq_mask), .vec_fetch(vec_fetch), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", what, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string what);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, what);
    endtask

    // falling edge on a pin, flag visible three edges later
    task automatic wait_sync();
        repeat (3) @(negedge clk);
    endtask

    task automatic release_pins();
        @(negedge clk);
        irq_pin_n = 1'b1; port_pin_n = 4'hF;
        wait_sync();
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(1'b0, 8'h00, "R1 reg0 after reset");
        rd(1'b1, 8'h00, "R1 reg1 after reset");
        check({7'd0, cpu_irq}, 8'h00, "R1 cpu_irq after reset");

        // R2 falling edge on dedicated pin, latency
        @(negedge clk); irq_pin_n = 1'b0;
        repeat (2) @(negedge clk);
        rd(1'b0, 8'h00, "R2 flag not yet set after two edges");
        @(negedge clk);
        rd(1'b0, 8'h80, "R2 flag set on third edge");
        check({7'd0, cpu_irq}, 8'h01, "R9 ext flag raises cpu_irq");

        // R4 write of flag bit and zero strobe has no effect
        wr(1'b0, 8'hFE);
        rd(1'b0, 8'h80, "R4 write without strobe ignored");
        wr(1'b0, 8'h01);
        rd(1'b0, 8'h00, "R4 strobe write clears");
        // R2 rising edge does not set
        release_pins();
        rd(1'b0, 8'h00, "R2 rising edge no set");

        // R4 vector fetch clears
        @(negedge clk); irq_pin_n = 1'b0;
        wait_sync();
        @(negedge clk); vec_fetch = 1'b1;
        @(negedge clk); vec_fetch = 1'b0;
        rd(1'b0, 8'h00, "R4 vector fetch clears");
        release_pins();

        // R3 port pins with enable off and on
        for (int cfg = 0; cfg < 2; cfg++) begin
            for (int p = 0; p < 4; p++) begin
                @(negedge clk); port_irq_en = cfg[0]; port_pin_n[p] = 1'b0;
                wait_sync();
                rd(1'b0, cfg[0] ? 8'h80 : 8'h00, $sformatf("R3 port %0d cfg %0d", p, cfg));
                wr(1'b0, 8'h01);
                release_pins();
            end
        end
        port_irq_en = 1'b0;

        // R8 external set collides with vector fetch
        @(negedge clk); irq_pin_n = 1'b0;
        repeat (2) @(negedge clk);
        vec_fetch = 1'b1;
        @(negedge clk); vec_fetch = 1'b0;
        rd(1'b0, 8'h80, "R8 ext set beats vector fetch");
        wr(1'b0, 8'h01);
        release_pins();

        // R7 enables and strobe readback
        wr(1'b1, 8'h3C);
        rd(1'b1, 8'h30, "R7 enables read back, strobes read 0");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h00, "R7 enables cleared");

        // R6 timer flags set and clear
        @(negedge clk); ovf_pulse = 1'b1; tick_pulse = 1'b1;
        @(negedge clk); ovf_pulse = 1'b0; tick_pulse = 1'b0;
        rd(1'b1, 8'hC0, "R6 both flags set by pulses");
        wr(1'b1, 8'h08);
        rd(1'b1, 8'h40, "R6 overflow strobe clears only overflow");
        wr(1'b1, 8'h04);
        rd(1'b1, 8'h00, "R6 tick strobe clears tick");

        // R8 timer pulse collides with strobe
        @(negedge clk);
        ovf_pulse = 1'b1; tick_pulse = 1'b1;
        bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h0C;
        @(negedge clk);
        ovf_pulse = 1'b0; tick_pulse = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(1'b1, 8'hC0, "R8 timer set beats strobe");

        // R9 exhaustive sweep of timer flags, enables, mask
        for (int m = 0; m < 32; m++) begin
            logic oe, te, of, tf, gm, exp_irq;
            oe = m[0]; te = m[1]; of = m[2]; tf = m[3]; gm = m[4];
            wr(1'b1, {2'b00, oe, te, 4'b1100});
            @(negedge clk); ovf_pulse = of; tick_pulse = tf; irq_mask = gm;
            @(negedge clk); ovf_pulse = 1'b0; tick_pulse = 1'b0;
            exp_irq = !gm && ((of && oe) || (tf && te));
            rd(1'b1, {of, tf, oe, te, 4'b0000}, $sformatf("R7 readback combo %0d", m));
            check({7'd0, cpu_irq}, {7'd0, exp_irq}, $sformatf("R9 cpu_irq combo %0d", m));
        end
        wr(1'b1, 8'h0C);

        // R9 external flag against mask
        @(negedge clk); irq_pin_n = 1'b0; irq_mask = 1'b1;
        wait_sync();
        check({7'd0, cpu_irq}, 8'h00, "R9 mask blocks ext request");
        irq_mask = 1'b0; #1;
        check({7'd0, cpu_irq}, 8'h01, "R9 unmasked ext request");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule